// File: doc/BRIEF.md
# Register-Driven Serial Flash Command Engine

This block is a host-programmed SPI master that runs one short serial-flash transaction each time it is started. The host fills a small byte-wide register window with an opcode, a three-byte address and one trailing data byte. It then writes a control byte that selects the outgoing length, the number of bytes to read back and the serial clock rate. The engine frames the transfer with an active-low chip select and shifts the bytes out in SPI mode 0. It collects up to three reply bytes into readable slots and shows a busy flag while it works.

The outgoing lengths allowed are 1, 2, 4 and 5 bytes, chosen by a 2-bit code. The address bytes are sent from the highest register offset down to the lowest. Firmware uses the block for short commands such as write-enable, status reads, byte program and small reads.

Top module: `spi_cmd_engine`

## Requirements
- R1: Reading offset 0 returns the busy flag in bit 7, with bits 6..0 reading 0. Busy reads 1 from the cycle after a start write until the transfer has ended and chip select is high again.
- R2: The byte written at offset 1 is always the first byte on the data output. Every byte goes out most significant bit first.
- R3: With write code 2 or 3, three address bytes follow the opcode: first the byte at offset 4, then offset 3, then offset 2.
- R4: The byte written at offset 7 is sent directly after the opcode with write code 1, and directly after the third address byte with write code 3.
- R5: Control bits [1:0] set the outgoing length: code 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 5. The transfer has exactly 8 x (outgoing + incoming) clock pulses.
- R6: Control bits [3:2] set the number of incoming bytes, from 0 to 3. These bytes are sampled after the outgoing bytes, while the data output stays 0. Reads of offsets 5, 6 and 7 return them in order of arrival.
- R7: A control write starts a transfer only when its bits [6:4] equal 4 (slow clock) or 5 (fast clock). Any other value starts nothing.
- R8: The slow serial clock has a period of SLOW_DIV system clocks (4 by default), and the fast one a period of FAST_DIV system clocks (2 by default).
- R9: The serial clock idles low and chip select idles high. Chip select falls half a serial-clock period before the first rising edge and rises half a period after the last falling edge. The data input is sampled on rising edges, and the data output changes only while the clock is low.
- R10: While busy, writes to any offset are ignored, including control writes that would start a transfer.
- R11: After reset, chip select is high, the serial clock is low, and every offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the engine with its default dividers, SLOW_DIV of 4 and FAST_DIV of 2. At these values the serial-clock period can be measured as exactly 20 ns or 10 ns against the 200 MHz system clock, and both rates are used. A five-byte write with three read bytes, the longest case, needs 64 serial bits. This fills the bench's 64-bit capture exactly, so every write code and read count can be compared bit for bit against the expected stream. The slow rate keeps a long transfer busy for enough cycles to place register writes and a second start inside it.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int TX_BYTES  = 5;
  localparam int ADR_BYTES = 3;
  localparam int RX_BYTES  = 3;
  localparam int TX_W      = TX_BYTES * BYTE_W;
  localparam int RX_W      = RX_BYTES * BYTE_W;
  localparam int OFS_W     = 3;
  localparam int BITS_W    = $clog2((TX_BYTES + RX_BYTES) * BYTE_W + 1);

  // register window offsets
  localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_OP    = 3'd1;
  localparam logic [OFS_W-1:0] OFS_A_LO  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_A_MID = 3'd3;
  localparam logic [OFS_W-1:0] OFS_A_HI  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_RX0   = 3'd5;
  localparam logic [OFS_W-1:0] OFS_RX1   = 3'd6;
  localparam logic [OFS_W-1:0] OFS_TAIL  = 3'd7;

  localparam logic [2:0] GO_SLOW = 3'd4;
  localparam logic [2:0] GO_FAST = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_TAIL} seq_state_e;

  typedef struct packed {
    logic       fast;
    logic [1:0] wcode;
    logic [1:0] rcnt;
  } xfer_cfg_t;

  function automatic int wr_bytes(input logic [1:0] code);
    case (code)
      2'd0:    wr_bytes = 1;
      2'd1:    wr_bytes = 2;
      2'd2:    wr_bytes = 4;
      default: wr_bytes = 5;
    endcase
  endfunction

  // left-aligned outgoing stream; address goes high offset first
  function automatic logic [TX_W-1:0] pack_tx(
      input logic [1:0] code, input logic [BYTE_W-1:0] op,
      input logic [BYTE_W-1:0] a_hi, input logic [BYTE_W-1:0] a_mid,
      input logic [BYTE_W-1:0] a_lo, input logic [BYTE_W-1:0] tail);
    case (code)
      2'd0:    pack_tx = {op, {(4*BYTE_W){1'b0}}};
      2'd1:    pack_tx = {op, tail, {(3*BYTE_W){1'b0}}};
      2'd2:    pack_tx = {op, a_hi, a_mid, a_lo, {BYTE_W{1'b0}}};
      default: pack_tx = {op, a_hi, a_mid, a_lo, tail};
    endcase
  endfunction
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int SLOW_HALF = SLOW_DIV / 2;
  localparam int FAST_HALF = FAST_DIV / 2;
  localparam int CW = ($clog2(SLOW_HALF) < 1) ? 1 : $clog2(SLOW_HALF);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
    tick  = run && (cnt_q == lim);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (SLOW_HALF > 1) begin : g_slow_chk
      // R8: slow half period spans more than one system clock
      p_slow_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fast && tick) |=> !tick);
    end
    if (FAST_HALF == 1) begin : g_fast_chk
      // R8: fast half period is a single system clock
      p_fast_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fast && $past(run)) |-> tick);
    end
  endgenerate
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [1:0]        rcnt,
  input  logic [RX_W-1:0]   rx_vec,
  output logic              start,
  output xfer_cfg_t         cfg,
  output logic [TX_W-1:0]   tx_vec,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] op_q, op_d, tail_q, tail_d;
  logic [ADR_BYTES-1:0][BYTE_W-1:0] adr_q, adr_d;
  logic [RX_BYTES-1:0][BYTE_W-1:0]  rx_q, rx_d;
  logic wr_ok;

  assign wr_ok = wr_en && !busy;

  always_comb begin
    op_d   = op_q;
    tail_d = tail_q;
    adr_d  = adr_q;
    rx_d   = rx_q;
    if (wr_ok) begin
      case (addr)
        OFS_OP:    op_d     = wdata;
        OFS_A_LO:  adr_d[0] = wdata;
        OFS_A_MID: adr_d[1] = wdata;
        OFS_A_HI:  adr_d[2] = wdata;
        OFS_TAIL:  tail_d   = wdata;
        default: ;
      endcase
    end
    if (done) begin
      for (int k = 0; k < RX_BYTES; k++) begin
        if (k < int'(rcnt))
          rx_d[k] = rx_vec[BYTE_W*(int'(rcnt)-1-k) +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      tail_q <= '0;
      adr_q  <= '0;
      rx_q   <= '0;
    end else begin
      op_q   <= op_d;
      tail_q <= tail_d;
      adr_q  <= adr_d;
      rx_q   <= rx_d;
    end
  end

  always_comb begin
    start     = wr_ok && (addr == OFS_CTRL) &&
                ((wdata[6:4] == GO_SLOW) || (wdata[6:4] == GO_FAST));
    cfg.fast  = (wdata[6:4] == GO_FAST);
    cfg.wcode = wdata[1:0];
    cfg.rcnt  = wdata[3:2];
    tx_vec    = pack_tx(cfg.wcode, op_q, adr_q[2], adr_q[1], adr_q[0], tail_q);
  end

  always_comb begin
    case (addr)
      OFS_CTRL:  rdata = {busy, 7'b0};
      OFS_OP:    rdata = op_q;
      OFS_A_LO:  rdata = adr_q[0];
      OFS_A_MID: rdata = adr_q[1];
      OFS_A_HI:  rdata = adr_q[2];
      OFS_RX0:   rdata = rx_q[0];
      OFS_RX1:   rdata = rx_q[1];
      default:   rdata = rx_q[2];
    endcase
  end

  // R10: staged bytes hold while a transfer runs
  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_q) && $stable(adr_q) && $stable(tail_q)));
  // R6: reply slots change only at the end of a transfer
  p_rx_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rx_q));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  xfer_cfg_t       cfg,
  input  logic [TX_W-1:0] tx_vec,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            run,
  output logic            fast,
  output logic            sclk,
  output logic            cs_n,
  output logic            mosi,
  output logic            done,
  output logic [1:0]      rcnt,
  output logic [RX_W-1:0] rx_vec
);
  seq_state_e        state_q, state_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic [RX_W-1:0]   rx_q, rx_d;
  logic [BITS_W-1:0] left_q, left_d, rdb_q, rdb_d;
  logic              sclk_q, sclk_d, cs_n_q, cs_n_d, fast_q, fast_d;
  logic [1:0]        rcnt_q, rcnt_d;

  always_comb begin
    state_d = state_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    left_d  = left_q;
    rdb_d   = rdb_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    fast_d  = fast_q;
    rcnt_d  = rcnt_q;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_XFER;
          cs_n_d  = 1'b0;
          tx_d    = tx_vec;
          fast_d  = cfg.fast;
          rcnt_d  = cfg.rcnt;
          left_d  = BITS_W'((wr_bytes(cfg.wcode) + int'(cfg.rcnt)) * BYTE_W);
          rdb_d   = BITS_W'(int'(cfg.rcnt) * BYTE_W);
        end
      end
      ST_XFER: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rx_d   = {rx_q[RX_W-2:0], miso};
          end else begin
            sclk_d = 1'b0;
            left_d = left_q - 1'b1;
            if (left_q == BITS_W'(1)) state_d = ST_TAIL;
            else                      tx_d    = {tx_q[TX_W-2:0], 1'b0};
          end
        end
      end
      default: begin
        if (tick) begin
          state_d = ST_IDLE;
          cs_n_d  = 1'b1;
          done    = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
      rx_q    <= '0;
      left_q  <= '0;
      rdb_q   <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      fast_q  <= 1'b0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      left_q  <= left_d;
      rdb_q   <= rdb_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      fast_q  <= fast_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign run    = busy;
  assign fast   = fast_q;
  assign sclk   = sclk_q;
  assign cs_n   = cs_n_q;
  assign mosi   = tx_q[TX_W-1];
  assign rcnt   = rcnt_q;
  assign rx_vec = rx_q;

  // R9: lines idle when nothing runs
  p_idle_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!sclk_q && cs_n_q));
  // R9: data output holds while the clock is high
  p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi));
  // R6: data output low during the read phase
  p_read_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_XFER) && (left_q <= rdb_q)) |-> !mosi);
  // R1: busy ends right after the closing step, chip select high
  p_done_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && cs_n_q));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int SLOW_DIV     = 4,
  parameter int FAST_DIV     = 2,
  parameter int RSYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic            rst_n_sync, start, busy, run, fast, tick, done;
  xfer_cfg_t       cfg;
  logic [TX_W-1:0] tx_vec;
  logic [RX_W-1:0] rx_vec;
  logic [1:0]      rcnt;

  spi_rst_sync #(.STAGES(RSYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  spi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .done(done), .rcnt(rcnt),
    .rx_vec(rx_vec), .start(start), .cfg(cfg), .tx_vec(tx_vec),
    .rdata(reg_rdata));

  spi_clk_div #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_div (
    .clk(clk), .rst_n(rst_n_sync), .run(run), .fast(fast), .tick(tick));

  spi_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n_sync), .start(start), .cfg(cfg),
    .tx_vec(tx_vec), .tick(tick), .miso(spi_miso), .busy(busy),
    .run(run), .fast(fast), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .done(done), .rcnt(rcnt), .rx_vec(rx_vec));

  // R1/R9: chip select low exactly while busy
  p_cs_busy_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    busy |-> !spi_cs_n);
  // R10: a start is never accepted while busy
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (busy && start) |-> 1'b0);
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int    total = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  int    nrise = 0;
  logic [63:0] cap = '0;
  logic [63:0] resp = '0;
  realtime t0, t1;

  always #2.5 clk = ~clk;

  spi_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // device model: reply bit index follows the count of rising edges
  assign spi_miso = (nrise < 64) ? resp[63 - nrise] : 1'b0;

  always @(posedge spi_sclk) begin
    cap = {cap[62:0], spi_mosi};
    if (nrise == 0) t0 = $realtime;
    if (nrise == 1) t1 = $realtime;
    nrise = nrise + 1;
  end

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd0, v);
      if (!v[7]) break;
    end
  endtask

  function automatic int nbytes(input logic [1:0] wc);
    return (wc == 2'd0) ? 1 : (wc == 2'd1) ? 2 : (wc == 2'd2) ? 4 : 5;
  endfunction

  task automatic run_cmd(input string tag, input logic [1:0] wc,
      input logic [1:0] rc, input bit fast, input logic [7:0] op,
      input logic [7:0] alo, input logic [7:0] amid, input logic [7:0] ahi,
      input logic [7:0] dat, input logic [63:0] reply);
    logic [7:0]  v;
    logic [39:0] txe;
    logic [63:0] expf;
    int n, wb, per;
    wr(3'd1, op); wr(3'd2, alo); wr(3'd3, amid); wr(3'd4, ahi); wr(3'd7, dat);
    resp = reply; nrise = 0; cap = '0;
    wr(3'd0, {1'b0, fast ? 3'd5 : 3'd4, rc, wc});
    rd(3'd0, v);
    chk(v == 8'h80, "R1 busy after start", v, 8'h80);
    wait_idle();
    wb = nbytes(wc);
    n  = 8 * (wb + int'(rc));
    case (wc)
      2'd0:    txe = {op, 32'h0};
      2'd1:    txe = {op, dat, 24'h0};
      2'd2:    txe = {op, ahi, amid, alo, 8'h0};
      default: txe = {op, ahi, amid, alo, dat};
    endcase
    expf = {txe, 24'h0} >> (64 - n);
    chk(nrise == n, {tag, " R5 pulse count"}, 64'(nrise), 64'(n));
    chk(cap == expf, {tag, " stream"}, cap, expf);
    per = $rtoi(t1 - t0 + 0.5);
    chk(per == (fast ? 10 : 20), "R8 sclk period ns", 64'(per), fast ? 10 : 20);
    for (int k = 0; k < int'(rc); k++) begin
      rd(3'(5 + k), v);
      chk(v == resp[63 - 8*(wb + k) -: 8], "R6 reply slot", v,
          resp[63 - 8*(wb + k) -: 8]);
    end
    chk(spi_cs_n && !spi_sclk, "R9 lines idle after", {spi_cs_n, spi_sclk}, 2'b10);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(spi_cs_n && !spi_sclk, "R11 idle lines", {spi_cs_n, spi_sclk}, 2'b10);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 8'h00, "R11 register zero", v, 8'h00);
    end
  endtask

  task automatic t_bad_start();
    logic [7:0] v;
    nrise = 0;
    wr(3'd0, 8'h63);
    wr(3'd0, 8'h0F);
    wr(3'd0, 8'h35);
    repeat (20) @(negedge clk);
    rd(3'd0, v);
    chk(v == 8'h00, "R7 no busy on bad code", v, 8'h00);
    chk(nrise == 0 && spi_cs_n, "R7 no transfer", 64'(nrise), 0);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    resp = 64'hA5A5_5A5A_0F0F_F0F0; nrise = 0; cap = '0;
    wr(3'd1, 8'h0B); wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'h56);
    wr(3'd7, 8'h78);
    wr(3'd0, 8'h4F);
    wr(3'd1, 8'hEE);
    wr(3'd2, 8'hDD);
    wr(3'd0, 8'h50);
    wait_idle();
    rd(3'd1, v);
    chk(v == 8'h0B, "R10 opcode kept", v, 8'h0B);
    rd(3'd2, v);
    chk(v == 8'h12, "R10 address kept", v, 8'h12);
    chk(nrise == 64, "R10 restart ignored", 64'(nrise), 64);
    chk(cap[63:24] == 40'h0B_5634_1278, "R10 stream unchanged", cap[63:24],
        40'h0B_5634_1278);
    rd(3'd0, v);
    chk(v == 8'h00, "R10 idle after", v, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    run_cmd("R2", 2'd0, 2'd0, 1'b0, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 64'h0);
    run_cmd("R2 R6", 2'd0, 2'd3, 1'b1, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h00,
            64'h00C2_2017_8800_0000);
    run_cmd("R4", 2'd1, 2'd2, 1'b1, 8'h01, 8'h00, 8'h00, 8'h00, 8'h3C,
            64'h0000_81E7_0000_0000);
    run_cmd("R3", 2'd2, 2'd1, 1'b0, 8'h03, 8'hC3, 8'h81, 8'h7E, 8'h00,
            64'h0000_0000_D200_0000);
    run_cmd("R3 R4", 2'd3, 2'd0, 1'b1, 8'h02, 8'h10, 8'h20, 8'h30, 8'h99, 64'h0);
    run_cmd("R4 R6", 2'd3, 2'd3, 1'b0, 8'hAB, 8'h01, 8'h02, 8'h03, 8'h44,
            64'hFFFF_FFFF_FF69_96C3);
    t_bad_start();
    t_busy_ignore();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule